// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a device. Four pins (test clock, mode select, serial data in, optional asynchronous reset) drive a sixteen-state controller. The controller walks a 4-bit instruction register and one of three data paths between the serial input and the serial output. The three data paths are a one-stage bypass stage, a read-only 32-bit identification word, and an external boundary-scan chain. The block does not hold the boundary-scan chain. It drives capture, shift and update strobes for the chain and takes the chain's serial output back in.

The active instruction decides which data path sits in the serial loop. One instruction raises a request that forces the device outputs to high impedance. The serial output is registered on the falling test-clock edge. A qualifying enable is high only while a shift state is active. Entering the reset state loads the identification instruction, so a fresh port reads its identity with no instruction scan.

Top module: `jtag_tap`

## Requirements
- R1: Five consecutive rising test-clock edges with `tms` high bring the controller to the reset state from any state. A following edge with `tms` low moves it to run-test/idle.
- R2: While `trst_n` is low the controller is held in the reset state, with no clock needed. In that condition the active instruction is identification, and `hiz_req`, `tdo_en` and `tdo` are 0.
- R3: The instruction register is 4 bits wide and shifts out least significant bit first. In the capture-IR state it loads the pattern 4'b0001, so the first four bits seen on `tdo` in a scan are 1,0,0,0.
- R4: A shifted opcode becomes the active instruction only on the rising edge that leaves the update-IR state. Until that edge the previous instruction stays in force.
- R5: Opcodes 4'h0 and 4'h1 place the boundary chain in the loop (`bsr_sel` = 1). `bsr_extest` is 1 only for 4'h0.
- R6: Opcode 4'h2 places the identification word in the loop. The word is {version[3:0], part[15:0], 11'h033, 1'b1} with defaults version 0 and part 16'h04E8. It is shifted out bit 0 first.
- R7: With the bypass stage selected, the stage loads 0 in capture-DR. Data on `tdo` then repeats `tdi` delayed by exactly one clock.
- R8: Opcode 4'hF, opcode 4'h3, and every opcode outside {0,1,2,3,F} select the bypass stage.
- R9: `hiz_req` is 1 exactly while 4'h3 is the active instruction.
- R10: With the boundary chain selected, `bsr_capture`, `bsr_shift` and `bsr_update` are high only in capture-DR, shift-DR and update-DR respectively. At most one of them is high at a time, and none is high when another path is selected.
- R11: `tdo` and `tdo_en` change only on falling test-clock edges. `tdo_en` is 1 only in shift-IR and shift-DR, and `tdo` is 0 whenever `tdo_en` is 0.
- R12: Whenever the controller is in the reset state, the active instruction is identification (4'h2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| hiz_req | output | 1 | Request to float all device outputs |
| bsr_sel | output | 1 | Boundary chain is the selected data path |
| bsr_extest | output | 1 | Boundary chain drives the pins (external test) |
| bsr_capture | output | 1 | Boundary chain parallel capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_so | input | 1 | Serial output of the boundary chain |

## Verification
The bench reads the identification word straight out of reset. A design that reset into bypass, or put the manufacturer field one place off, returns a different 32-bit value. A bypass scan must show a leading 0 and then `tdi` one clock late; a missing capture clear or an extra pipeline stage breaks that pattern. The high-impedance request is sampled while the controller sits in update-IR and again one edge later, which catches a design that applies opcodes while they are still being shifted. A design that updated `tdo` on the rising edge fails the mid-cycle sample. A model chain driven by the strobes checks capture, shift and update ordering. Further scans check that unknown opcodes fall back to bypass, and that both reset routes (five TMS ones and the asynchronous pin) restore the identification instruction.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'h1;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'h2;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 4'h3;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  // Controller transition on one rising edge.
  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    tap_state_e n;
    unique case (s)
      ST_TLR:    n = m ? ST_TLR    : ST_RTI;
      ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: n = m ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: n = m ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  n = m ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

  // Data path chosen by an opcode; anything unlisted falls back to bypass.
  function automatic dr_path_e path_of(logic [IR_W-1:0] op);
    dr_path_e p;
    case (op)
      OP_EXTEST, OP_SAMPLE: p = PATH_BSR;
      OP_IDCODE:            p = PATH_ID;
      default:              p = PATH_BYP;
    endcase
    return p;
  endfunction

  function automatic logic [ID_W-1:0] make_id(logic [3:0] ver, logic [15:0] part,
                                              logic [10:0] mfr);
    return {ver, part, mfr, 1'b1};
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st,
  output tap_state_e st_nxt
);
  assign st_nxt = tap_next(st, tms);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= st_nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      st,
  input  tap_state_e      st_nxt,
  output logic [IR_W-1:0] ir_act,
  output logic            ir_so
);
  logic [IR_W-1:0] ir_sh;

  assign ir_so = ir_sh[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh  <= IR_CAPTURE;
      ir_act <= OP_IDCODE;
    end else begin
      case (st)
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        default:   ir_sh <= ir_sh;
      endcase
      if (st_nxt == ST_TLR)    ir_act <= OP_IDCODE;
      else if (st == ST_UP_IR) ir_act <= ir_sh;
    end
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e st,
  input  dr_path_e   path,
  output logic       byp_q,
  output logic       id_so
);
  logic [ID_W-1:0] id_sh;

  assign id_so = id_sh[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_sh <= ID_VALUE;
    end else begin
      if (path == PATH_BYP) begin
        if (st == ST_CAP_DR)     byp_q <= 1'b0;
        else if (st == ST_SH_DR) byp_q <= tdi;
      end
      if (path == PATH_ID) begin
        if (st == ST_CAP_DR)     id_sh <= ID_VALUE;
        else if (st == ST_SH_DR) id_sh <= {tdi, id_sh[ID_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
  import tap_pkg::*;
#(
  parameter logic [15:0] PART_NUM = 16'h04E8,
  parameter logic [3:0]  VERSION  = 4'h0,
  parameter logic [10:0] MFR_ID   = 11'h033
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  output logic hiz_req,
  output logic bsr_sel,
  output logic bsr_extest,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  input  logic bsr_so
);
  localparam logic [ID_W-1:0] ID_VALUE = make_id(VERSION, PART_NUM, MFR_ID);

  tap_state_e      st, st_nxt;
  logic [IR_W-1:0] ir_act;
  logic            ir_so, byp_q, id_so;
  dr_path_e        path;

  // Named events for the checker.
  logic shifting, in_cap_dr, in_sh_dr, in_up_dr;
  logic serial_mux;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .st_nxt(st_nxt)
  );

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .st_nxt(st_nxt),
    .ir_act(ir_act), .ir_so(ir_so)
  );

  assign path = path_of(ir_act);

  tap_dr #(.ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .path(path),
    .byp_q(byp_q), .id_so(id_so)
  );

  assign in_cap_dr = (st == ST_CAP_DR);
  assign in_sh_dr  = (st == ST_SH_DR);
  assign in_up_dr  = (st == ST_UP_DR);
  assign shifting  = in_sh_dr || (st == ST_SH_IR);

  assign hiz_req     = (ir_act == OP_HIGHZ);
  assign bsr_sel     = (path == PATH_BSR);
  assign bsr_extest  = (ir_act == OP_EXTEST);
  assign bsr_capture = bsr_sel && in_cap_dr;
  assign bsr_shift   = bsr_sel && in_sh_dr;
  assign bsr_update  = bsr_sel && in_up_dr;

  always_comb begin
    serial_mux = 1'b0;
    if (st == ST_SH_IR) serial_mux = ir_so;
    else if (in_sh_dr) begin
      case (path)
        PATH_ID:  serial_mux = id_so;
        PATH_BSR: serial_mux = bsr_so;
        default:  serial_mux = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= shifting ? serial_mux : 1'b0;
      tdo_en <= shifting;
    end
  end
endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      st,
  input tap_state_e      st_nxt,
  input logic [IR_W-1:0] ir_act,
  input dr_path_e        path,
  input logic            byp_q,
  input logic            hiz_req,
  input logic            tdo_en,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              ones_cnt <= '0;
    else if (!tms)            ones_cnt <= '0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (st == ST_TLR));

  a_r4_ir_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (st != ST_UP_IR && st_nxt != ST_TLR) |=> $stable(ir_act));

  a_r7_bypass_clear: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_CAP_DR && path == PATH_BYP) |=> !byp_q);

  a_r9_hiz_after_update: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(hiz_req) |-> ($past(st) == ST_UP_IR));

  a_r10_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  a_r11_enable_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (st == ST_SH_IR || st == ST_SH_DR));

  a_r12_reset_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR) |-> (ir_act == OP_IDCODE));
endmodule

bind jtag_tap jtag_tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .st_nxt(st_nxt),
  .ir_act(ir_act), .path(path), .byp_q(byp_q), .hiz_req(hiz_req),
  .tdo_en(tdo_en), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
  .bsr_update(bsr_update)
);

// File: tb/sim_jtag_tap.sv
module sim_jtag_tap;
  localparam int TCK_PERIOD = 20;
  localparam logic [31:0] EXP_ID = {4'h0, 16'h04E8, 11'h033, 1'b1};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en, hiz_req, bsr_sel, bsr_extest;
  logic bsr_capture, bsr_shift, bsr_update, bsr_so;
  logic [7:0] chain = 8'h00, upd_copy = 8'h00;
  int n_chk = 0, n_bad = 0;

  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_tap u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .hiz_req(hiz_req), .bsr_sel(bsr_sel), .bsr_extest(bsr_extest),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .bsr_so(bsr_so)
  );

  // Model of an 8-cell boundary chain driven by the strobes.
  always @(posedge tck) begin
    if (bsr_capture)    chain <= 8'hA5;
    else if (bsr_shift) chain <= {tdi, chain[7:1]};
    if (bsr_update)     upd_copy <= chain;
  end
  assign bsr_so = chain[0];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: sample tdo in the low phase, then drive tms/tdi for the next rise.
  task automatic step(input logic m, input logic d, output logic o, output logic e);
    @(negedge tck); #1;
    o = tdo; e = tdo_en;
    tms = m; tdi = d;
  endtask

  task automatic ir_scan(input logic [3:0] op, output logic [3:0] cap,
                         output logic hiz_upd);
    logic o, e;
    step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o, e);
      cap[i] = o;
    end
    step(1, 0, o, e);
    step(0, 0, o, e);
    hiz_upd = hiz_req;
    @(posedge tck); #1;
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout,
                         output logic en_ok);
    logic o, e;
    dout = '0; en_ok = 1'b1;
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, e);
      dout[i] = o;
      if (!e) en_ok = 1'b0;
    end
    step(1, 0, o, e); step(0, 0, o, e);
    @(posedge tck); #1;
  endtask

  task automatic do_reset();
    logic o, e;
    trst_n = 1'b0; tms = 1'b1;
    repeat (2) @(negedge tck);
    #1;
    chk(tdo_en == 0 && tdo == 0, "R2 outputs idle in reset", {tdo_en, tdo}, 0);
    chk(hiz_req == 0 && bsr_sel == 0, "R2 no hiz or chain select", {hiz_req, bsr_sel}, 0);
    trst_n = 1'b1;
    step(0, 0, o, e);
  endtask

  task automatic t_idcode();
    logic [63:0] d; logic ok;
    dr_scan(32, 64'h0, d, ok);
    chk(d[31:0] == EXP_ID, "R6 R12 id word after reset", d[31:0], EXP_ID);
    chk(ok, "R11 tdo_en high during shift", ok, 1);
  endtask

  task automatic t_ir_capture();
    logic [3:0] c; logic h;
    ir_scan(4'hF, c, h);
    chk(c == 4'b0001, "R3 capture pattern", c, 4'b0001);
  endtask

  task automatic t_bypass(input logic [15:0] pat, input string tag);
    logic [63:0] d; logic ok;
    dr_scan(16, {48'h0, pat}, d, ok);
    chk(d[15:0] == {pat[14:0], 1'b0}, tag, d[15:0], {pat[14:0], 1'b0});
  endtask

  task automatic t_falling_edge();
    logic o, e;
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    step(0, 1, o, e);
    @(posedge tck); #1;
    chk(tdo == 0, "R11 tdo holds across rising edge", tdo, 0);
    step(1, 0, o, e);
    chk(o == 1, "R11 tdo updates on falling edge", o, 1);
    step(1, 0, o, e); step(0, 0, o, e);
    step(0, 0, o, e);
    chk(e == 0 && o == 0, "R11 tdo idle outside shift", {e, o}, 0);
  endtask

  task automatic t_unknown();
    logic [3:0] c; logic h;
    ir_scan(4'h7, c, h);
    chk(hiz_req == 0, "R9 unknown opcode no hiz", hiz_req, 0);
    t_bypass(16'h5A3C, "R8 unknown opcode uses bypass");
  endtask

  task automatic t_highz();
    logic [3:0] c; logic h;
    ir_scan(4'h3, c, h);
    chk(h == 0, "R4 hiz not active in update-IR", h, 0);
    chk(hiz_req == 1, "R9 hiz after update edge", hiz_req, 1);
    t_bypass(16'h0F31, "R8 high-z uses bypass");
    ir_scan(4'h2, c, h);
    chk(h == 1, "R4 old instruction held until update edge", h, 1);
    chk(hiz_req == 0, "R9 hiz drops with new instruction", hiz_req, 0);
    t_idcode();
  endtask

  task automatic t_boundary();
    logic [3:0] c; logic h; logic [63:0] d; logic ok;
    ir_scan(4'h0, c, h);
    chk(bsr_sel == 1 && bsr_extest == 1, "R5 extest selects chain", {bsr_sel, bsr_extest}, 2'b11);
    dr_scan(8, 64'h3C, d, ok);
    chk(d[7:0] == 8'hA5, "R10 captured chain shifted out", d[7:0], 8'hA5);
    chk(upd_copy == 8'h3C, "R10 update after shift", upd_copy, 8'h3C);
    ir_scan(4'h1, c, h);
    chk(bsr_sel == 1 && bsr_extest == 0, "R5 sample selects chain", {bsr_sel, bsr_extest}, 2'b10);
    ir_scan(4'h2, c, h);
    chk(bsr_sel == 0, "R10 chain deselected for id", bsr_sel, 0);
  endtask

  task automatic t_tms_reset();
    logic [3:0] c; logic h; logic o, e;
    ir_scan(4'h3, c, h);
    step(1, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < 5; i++) step(1, 0, o, e);
    step(0, 0, o, e);
    @(posedge tck); #1;
    chk(hiz_req == 0, "R1 R12 five ones restore idcode", hiz_req, 0);
    t_idcode();
  endtask

  task automatic t_async_reset();
    logic [3:0] c; logic h; logic o, e;
    ir_scan(4'h3, c, h);
    @(negedge tck); #3;
    trst_n = 1'b0;
    #1;
    chk(hiz_req == 0, "R2 async reset clears instruction", hiz_req, 0);
    @(negedge tck); #1;
    trst_n = 1'b1; tms = 1'b0;
    step(0, 0, o, e);
    t_idcode();
  endtask

  initial begin
    #(TCK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    t_idcode();
    t_ir_capture();
    t_bypass(16'hB3C5, "R7 bypass one-clock delay");
    t_falling_edge();
    t_unknown();
    t_highz();
    t_boundary();
    t_tms_reset();
    t_async_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule